// File: doc/BRIEF.md
# Sampling Converter Conversion and Readout Controller

This controller sequences a 12-bit sampling converter that reports its result over a serial line. After a start request it drives the active-low convert-start line low for a short pulse. It then waits long enough for the conversion to finish, clocks the result out over a serial clock, and returns the bits as one parallel word with a single-cycle valid strobe. Every analog-facing time is a cycle count, derived from the system clock period and parameters given in nanoseconds.

There are two conversion modes, and the user picks one with each request. In normal mode the conversion time is counted from the falling edge of convert-start. In low-power mode the converter first has to wake up, and that wake-up time runs from the rising edge of the pulse. For this reason the pulse stays short in both modes.

Top module: `adc_sample_ctrl`

## Requirements
- R1: After reset and whenever idle, convst_n_o is 1, sclk_o is 0, busy_o is 0 and valid_o is 0.
- R2: Each accepted request drives convst_n_o low for exactly PULSE_CYC system cycles (4 cycles, 40 ns, at defaults).
- R3: With mode_i = 0 (normal), the first SCLK rising edge comes at least 8 µs after the convert-start falling edge.
- R4: With mode_i = 1 (low-power), the first SCLK rising edge comes at least 14 µs after the convert-start rising edge, and the convert-start low time is at most 6 µs.
- R5: Each conversion produces exactly 12 SCLK pulses. Each high phase lasts at least 40 ns, each low phase at least 100 ns, and each period at least 100 ns. SCLK never pulses while convert-start is low.
- R6: Each data bit is captured when the SCLK low phase ends, at least 100 ns after the falling edge that launched it. The first bit is the MSB, and data_o is the straight binary value of the 12 bits.
- R7: valid_o is high for exactly one cycle per conversion, and data_o holds the converted word in that cycle.
- R8: busy_o is high from the cycle after the request through the valid cycle, and it drops in the cycle after valid_o.
- R9: A start request while busy_o is high is ignored: no second convert-start pulse, and no change to mode, result or timing.
- R10: valid_o rises exactly PULSE_CYC + wait + 12·(HIGH_CYC+LOW_CYC) + 1 cycles after the request edge. The wait is ceil(8000 ns/clk) − PULSE_CYC in normal mode and ceil(14000 ns/clk) in low-power mode.
- R11: Elaboration fails if the derived SCLK phases or period, the pulse width, or the access margin break their limits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, sampled while idle |
| mode_i | input | 1 | 0 = normal, 1 = low-power; sampled with start_i |
| busy_o | output | 1 | Conversion in progress |
| data_o | output | 12 | Converted word, straight binary |
| valid_o | output | 1 | One-cycle strobe marking data_o valid |
| convst_n_o | output | 1 | Active-low convert-start to the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| sdata_i | input | 1 | Serial data from the converter |

## Verification
The converter model in the bench changes its data output 10 ns after each SCLK falling edge to the inverted bit, and only 95 ns after the edge to the true bit. A controller that captured on the rising edge too early, or one cycle early, would return inverted bits. The bench runs walking-one words, the all-zero and all-one words, and alternating patterns in both modes. A wrong MSB-first order, or a miscounted bit, shows up as a wrong word. A request pulsed halfway through a busy conversion with the opposite mode would show up as a second convert-start edge or a changed latency, since the bench predicts latency exactly for each mode. The model also measures every pulse width and wait, and a short wait or a stretched pulse is flagged there.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PULSE,
    ST_WAIT,
    ST_HIGH,
    ST_LOW,
    ST_DONE
  } ctrl_state_e;

  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction
endpackage

// File: rtl/adc_ctrl_timer.sv
module adc_ctrl_timer #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? load_val_i : cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/adc_ctrl_shifter.sv
module adc_ctrl_shifter #(
  parameter int NBITS = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en_i,
  input  logic             bit_i,
  output logic [NBITS-1:0] word_o
);
  logic [NBITS-1:0] word_q, word_d;

  always_comb word_d = {word_q[NBITS-2:0], bit_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          word_q <= '0;
    else if (shift_en_i) word_q <= word_d;
  end

  assign word_o = word_q;
endmodule

// File: rtl/adc_sample_ctrl.sv
module adc_sample_ctrl
  import adc_ctrl_pkg::*;
#(
  parameter int CLK_NS          = 10,
  parameter int NBITS           = 12,
  parameter int PULSE_NS        = 40,
  parameter int LP_PULSE_MAX_NS = 6000,
  parameter int CONV_NS         = 8000,
  parameter int LP_WAKE_NS      = 14000,
  parameter int SCLK_HIGH_NS    = 40,
  parameter int SCLK_LOW_NS     = 100,
  parameter int SCLK_PHASE_MIN  = 40,
  parameter int SCLK_PERIOD_MIN = 100,
  parameter int ACCESS_NS       = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             mode_i,
  output logic             busy_o,
  output logic [NBITS-1:0] data_o,
  output logic             valid_o,
  output logic             convst_n_o,
  output logic             sclk_o,
  input  logic             sdata_i
);
  localparam int PULSE_CYC = ns_to_cyc(PULSE_NS, CLK_NS);
  localparam int HIGH_CYC  = ns_to_cyc(SCLK_HIGH_NS, CLK_NS);
  localparam int LOW_CYC   = ns_to_cyc(SCLK_LOW_NS, CLK_NS);
  localparam int NORM_WAIT = ns_to_cyc(CONV_NS, CLK_NS) - PULSE_CYC;
  localparam int LP_WAIT   = ns_to_cyc(LP_WAKE_NS, CLK_NS);
  localparam int MAXC      = (LP_WAIT > NORM_WAIT) ? LP_WAIT : NORM_WAIT;
  localparam int TW        = $clog2(MAXC + 1);
  localparam int BW        = $clog2(NBITS);

  // R11: elaboration-time limits on the derived timing
  if (HIGH_CYC * CLK_NS < SCLK_PHASE_MIN) begin : g_bad_high
    $error("SCLK high phase too short");
  end
  if (LOW_CYC * CLK_NS < SCLK_PHASE_MIN || LOW_CYC * CLK_NS < ACCESS_NS) begin : g_bad_low
    $error("SCLK low phase shorter than phase minimum or access time");
  end
  if ((HIGH_CYC + LOW_CYC) * CLK_NS < SCLK_PERIOD_MIN) begin : g_bad_period
    $error("SCLK period exceeds maximum frequency");
  end
  if (PULSE_CYC * CLK_NS > LP_PULSE_MAX_NS || NORM_WAIT < 1 || NBITS < 2) begin : g_bad_pulse
    $error("convert-start pulse or wait count out of range");
  end

  // reset: asynchronous assert, synchronous release
  logic rst_s1_q, rst_s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  logic rst_int_n;
  assign rst_int_n = rst_s2_q;

  ctrl_state_e    state_q, state_d;
  logic           mode_q, mode_en;
  logic [BW-1:0]  bit_q, bit_d;
  logic           bit_en;
  logic           tmr_load, tmr_zero, shift_en;
  logic [TW-1:0]  tmr_val;
  logic           convst_n_q, sclk_q;

  adc_ctrl_timer #(.W(TW)) u_timer (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  adc_ctrl_shifter #(.NBITS(NBITS)) u_shift (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .shift_en_i (shift_en),
    .bit_i      (sdata_i),
    .word_o     (data_o)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    shift_en = 1'b0;
    mode_en  = 1'b0;
    bit_en   = 1'b0;
    bit_d    = bit_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d  = ST_PULSE;
        tmr_load = 1'b1;
        tmr_val  = TW'(PULSE_CYC - 1);
        mode_en  = 1'b1;
      end
      ST_PULSE: if (tmr_zero) begin
        state_d  = ST_WAIT;
        tmr_load = 1'b1;
        tmr_val  = mode_q ? TW'(LP_WAIT - 1) : TW'(NORM_WAIT - 1);
      end
      ST_WAIT: if (tmr_zero) begin
        state_d  = ST_HIGH;
        tmr_load = 1'b1;
        tmr_val  = TW'(HIGH_CYC - 1);
        bit_en   = 1'b1;
        bit_d    = '0;
      end
      ST_HIGH: if (tmr_zero) begin
        state_d  = ST_LOW;
        tmr_load = 1'b1;
        tmr_val  = TW'(LOW_CYC - 1);
      end
      ST_LOW: if (tmr_zero) begin
        shift_en = 1'b1;
        if (bit_q == BW'(NBITS - 1)) begin
          state_d = ST_DONE;
        end else begin
          state_d  = ST_HIGH;
          tmr_load = 1'b1;
          tmr_val  = TW'(HIGH_CYC - 1);
          bit_en   = 1'b1;
          bit_d    = bit_q + BW'(1);
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q    <= ST_IDLE;
      mode_q     <= 1'b0;
      bit_q      <= '0;
      convst_n_q <= 1'b1;
      sclk_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      convst_n_q <= (state_d != ST_PULSE);
      sclk_q     <= (state_d == ST_HIGH);
      if (mode_en) mode_q <= mode_i;
      if (bit_en)  bit_q  <= bit_d;
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign valid_o    = (state_q == ST_DONE);
  assign convst_n_o = convst_n_q;
  assign sclk_o     = sclk_q;
endmodule

// File: rtl/adc_sample_ctrl_chk.sv
module adc_sample_ctrl_chk #(
  parameter int PULSE_CYC = 4,
  parameter int NBITS     = 12
) (
  input logic clk,
  input logic rst_n,
  input logic busy_o,
  input logic valid_o,
  input logic convst_n_o,
  input logic sclk_o
);
  logic [15:0] low_cnt_q;
  logic [15:0] rise_cnt_q;
  logic        sclk_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt_q   <= '0;
      rise_cnt_q  <= '0;
      sclk_prev_q <= 1'b0;
    end else begin
      sclk_prev_q <= sclk_o;
      low_cnt_q   <= convst_n_o ? '0 : low_cnt_q + 16'd1;
      if (!convst_n_o)               rise_cnt_q <= '0;
      else if (sclk_o && !sclk_prev_q) rise_cnt_q <= rise_cnt_q + 16'd1;
    end
  end

  // R1
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (convst_n_o && !sclk_o && !valid_o));

  // R2
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(convst_n_o) |-> (low_cnt_q == 16'(PULSE_CYC)));

  // R5
  sclk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !convst_n_o |-> !sclk_o);

  // R5
  sclk_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (rise_cnt_q == 16'(NBITS)));

  // R7
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  // R8
  busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> busy_o ##1 !busy_o);

  // R9
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(convst_n_o) |-> !$past(busy_o));
endmodule

bind adc_sample_ctrl adc_sample_ctrl_chk #(
  .PULSE_CYC (PULSE_CYC),
  .NBITS     (NBITS)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy_o     (busy_o),
  .valid_o    (valid_o),
  .convst_n_o (convst_n_o),
  .sclk_o     (sclk_o)
);

// File: tb/adc_sample_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_sample_ctrl_tb_top;
  localparam int NB     = 12;
  localparam int CLKNS  = 10;
  localparam int P_CYC  = 4;
  localparam int H_CYC  = 4;
  localparam int L_CYC  = 10;
  localparam int NW_CYC = 8000 / CLKNS - P_CYC;
  localparam int LW_CYC = 14000 / CLKNS;

  logic          clk = 1'b0;
  logic          rst_n, start_i, mode_i, sdata_i;
  logic          busy_o, valid_o, convst_n_o, sclk_o;
  logic [NB-1:0] data_o;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  adc_sample_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .busy_o(busy_o), .data_o(data_o), .valid_o(valid_o),
    .convst_n_o(convst_n_o), .sclk_o(sclk_o), .sdata_i(sdata_i)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // behavioural converter
  logic [NB-1:0] model_word;
  bit            cur_mode;
  bit            armed = 0;
  bit            first_pending = 0;
  bit            sclk_seen = 0;
  int            idx;
  int            convst_falls, sclk_rises;
  time           t_cfall, t_crise, t_srise, t_sfall;

  always @(negedge convst_n_o) begin
    t_cfall = $time;
    armed = 1;
    first_pending = 1;
    sclk_seen = 0;
    idx = NB - 1;
    convst_falls++;
  end

  always @(posedge convst_n_o) if (armed) begin
    chk(($time - t_cfall) >= 40, "R2 pulse width ns", $time - t_cfall, 40);
    if (cur_mode)
      chk(($time - t_cfall) <= 6000, "R4 pulse limit ns", $time - t_cfall, 6000);
    t_crise = $time;
  end

  always @(posedge sclk_o) if (armed) begin
    if (first_pending) begin
      if (cur_mode)
        chk(($time - t_crise) >= 14000, "R4 wake wait ns", $time - t_crise, 14000);
      else
        chk(($time - t_cfall) >= 8000, "R3 conversion wait ns", $time - t_cfall, 8000);
      first_pending = 0;
    end else begin
      chk(($time - t_srise) >= 100, "R5 sclk period ns", $time - t_srise, 100);
      chk(($time - t_sfall) >= 100, "R5 sclk low ns", $time - t_sfall, 100);
    end
    sclk_seen = 1;
    t_srise = $time;
    sclk_rises++;
  end

  always @(negedge sclk_o) if (armed && sclk_seen) begin
    logic b;
    chk(($time - t_srise) >= 40, "R5 sclk high ns", $time - t_srise, 40);
    t_sfall = $time;
    b = (idx >= 0) ? model_word[idx] : 1'b0;
    idx--;
    #10 sdata_i = ~b;
    #85 sdata_i = b;
  end

  task automatic run_conv(input logic [NB-1:0] w, input bit m, input bit poke);
    int cyc = 1;
    int busy_low = 0;
    int exp_cyc;
    model_word = w;
    cur_mode = m;
    convst_falls = 0;
    sclk_rises = 0;
    exp_cyc = P_CYC + (m ? LW_CYC : NW_CYC) + NB * (H_CYC + L_CYC) + 1;
    @(negedge clk);
    start_i = 1'b1;
    mode_i = m;
    @(negedge clk);
    start_i = 1'b0;
    while (!valid_o && cyc < 3000) begin
      if (!busy_o) busy_low++;
      if (poke && (cyc == 20 || cyc == 900)) begin
        start_i = 1'b1;       // R9 request while busy
        mode_i = ~m;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start_i = 1'b0;
    chk(valid_o == 1'b1, "R10 valid reached", valid_o, 1);
    chk(cyc == exp_cyc, "R10 latency cycles", cyc, exp_cyc);
    chk(data_o == w, "R6 captured word", data_o, w);
    chk(busy_o == 1'b1 && busy_low == 0, "R8 busy held", busy_low, 0);
    chk(sclk_rises == NB, "R5 sclk pulses", sclk_rises, NB);
    chk(convst_falls == 1, "R9 single convert-start", convst_falls, 1);
    @(negedge clk);
    chk(valid_o == 1'b0, "R7 valid one cycle", valid_o, 0);
    chk(busy_o == 1'b0, "R8 busy drop", busy_o, 0);
    chk(convst_n_o == 1'b1 && sclk_o == 1'b0, "R1 idle lines", {convst_n_o, sclk_o}, 2);
  endtask

  initial begin
    #1_500_000;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start_i = 1'b0;
    mode_i = 1'b0;
    sdata_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(convst_n_o == 1'b1, "R1 reset convst", convst_n_o, 1);
    chk(sclk_o == 1'b0, "R1 reset sclk", sclk_o, 0);
    chk(busy_o == 1'b0, "R1 reset busy", busy_o, 0);
    chk(valid_o == 1'b0, "R1 reset valid", valid_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_conv(12'h000, 1'b0, 1'b0);
    run_conv(12'hFFF, 1'b1, 1'b0);
    run_conv(12'hAAA, 1'b0, 1'b1);
    run_conv(12'h555, 1'b1, 1'b1);
    for (int i = 0; i < NB; i++) run_conv(NB'(1) << i, i[0], i == 5);
    for (int i = 1; i < 4; i++) run_conv(NB'(i * 12'h359), i[0], 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule